// File: doc/BRIEF.md
# USB Frame Interval Timer

This block turns a bit-time enable into the 1 ms frame timing of a USB host. A programmable interval sets how many bit times each frame lasts. A remaining-time counter counts down through the frame. Each time that counter reloads, a start-of-frame pulse is raised and a 16-bit frame number advances. A toggle bit written together with the interval is copied into the counter's own toggle when the reload happens. Software compares the two toggles to learn when a new interval has taken effect.

Within each frame, a largest-packet budget is loaded at the frame start and counts down once per bit time. Two compare flags are computed against the remaining time. One marks that periodic-list work may begin. The other marks that enough time is left to start a low-speed transaction. Timing runs only while the operational-state input is high. On entry to that state, the first start of frame follows one full frame later.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, the remaining count, remaining toggle, frame number, budget, all flags and both pulses are 0.
- R2: While running, the remaining count falls by 1 on each clock where `bit_tick_i` is high and the count is not 0. With `bit_tick_i` low, it holds its value and no pulse is raised.
- R3: While running, a tick that finds the remaining count at 0 reloads it from the interval register. In the same clock, the remaining toggle takes the interval toggle. A frame is therefore interval+1 ticks long, and a write to the interval register affects only frames that start after it.
- R4: Each reload raises `sof_o` for exactly one clock and increments `frame_num_o` by 1 (wrapping 0xFFFF to 0x0000). The new values are visible in the clock where `sof_o` is high.
- R5: `fno_o` pulses together with `sof_o` exactly when bit 15 of the frame number changes, whether 0→1 (new value 0x8000) or 1→0 (new value 0x0000).
- R6: On every reload and on entry to running, `budget_o` is loaded with the largest-packet value. It then falls by 1 per tick and stops at 0. `pkt_fits_o` is high while running and `budget_o` is nonzero.
- R7: `periodic_ok_o` is high while running and the remaining count is less than or equal to the periodic-start value.
- R8: `ls_ok_o` is high while running and the remaining count is strictly greater than the 12-bit low-speed threshold.
- R9: The first clock with `oper_i` high loads the remaining count from the interval register, without a pulse. The first `sof_o` follows interval+1 ticks later.
- R10: While `oper_i` is low, the remaining count and budget are 0, no pulse is raised, all flags are low, and the frame number holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-clock enable per bit time |
| oper_i | input | 1 | Controller is in operational state |
| ivl_we_i | input | 1 | Write strobe for interval, toggle and packet budget |
| ivl_i | input | 14 | Frame interval (frame length minus one, in bit times) |
| ivl_tgl_i | input | 1 | Interval toggle written with the interval |
| pkt_i | input | 15 | Largest-packet budget loaded each frame |
| pst_we_i | input | 1 | Write strobe for periodic start |
| pst_i | input | 14 | Periodic-start value |
| lst_we_i | input | 1 | Write strobe for low-speed threshold |
| lst_i | input | 12 | Low-speed threshold |
| rem_o | output | 14 | Remaining bit times in current frame |
| rem_tgl_o | output | 1 | Remaining toggle |
| frame_num_o | output | 16 | Frame number |
| sof_o | output | 1 | Start-of-frame pulse |
| fno_o | output | 1 | Frame-number MSB change pulse |
| budget_o | output | 15 | Packet budget counter |
| pkt_fits_o | output | 1 | Budget nonzero |
| periodic_ok_o | output | 1 | Periodic processing may begin |
| ls_ok_o | output | 1 | Low-speed transaction may start |

## Verification
The bench measures frame lengths in ticks, both the first frame after entering the operational state and frames after an interval rewrite. A design with an off-by-one reload would give frames of interval or interval+2 ticks, and one that reloads on write would shorten the frame that is already running. It walks the frame number through both MSB transitions with a one-tick interval. A design that detects only the rising edge of bit 15 would raise one overflow pulse instead of two. It also checks the compare flags at the exact boundary values and the budget at saturation, where a wrong comparison or an underflow would show up as a flag flipping one tick early or the budget wrapping to its maximum.

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;
  localparam int unsigned IVL_W_DEF = 14;
  localparam int unsigned FN_W_DEF  = 16;
  localparam int unsigned PKT_W_DEF = 15;
  localparam int unsigned LST_W_DEF = 12;
  localparam int unsigned IVL_RST_DEF = 11999;

  typedef enum logic [1:0] {
    FT_IDLE  = 2'd0,
    FT_START = 2'd1,
    FT_RUN   = 2'd2
  } ft_phase_e;
endpackage

// File: rtl/ft_cfg_regs.sv
module ft_cfg_regs #(
  parameter int unsigned IVL_W   = 14,
  parameter int unsigned PKT_W   = 15,
  parameter int unsigned LST_W   = 12,
  parameter int unsigned IVL_RST = 11999
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ivl_we_i,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             ivl_tgl_i,
  input  logic [PKT_W-1:0] pkt_i,
  input  logic             pst_we_i,
  input  logic [IVL_W-1:0] pst_i,
  input  logic             lst_we_i,
  input  logic [LST_W-1:0] lst_i,
  output logic [IVL_W-1:0] ivl_o,
  output logic             ivl_tgl_o,
  output logic [PKT_W-1:0] pkt_o,
  output logic [IVL_W-1:0] pst_o,
  output logic [LST_W-1:0] lst_o
);
  localparam logic [IVL_W-1:0] IVL_INIT = IVL_W'(IVL_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_o     <= IVL_INIT;
      ivl_tgl_o <= 1'b0;
      pkt_o     <= '0;
    end else if (ivl_we_i) begin
      ivl_o     <= ivl_i;
      ivl_tgl_o <= ivl_tgl_i;
      pkt_o     <= pkt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pst_o <= '0;
    else if (pst_we_i) pst_o <= pst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lst_o <= '0;
    else if (lst_we_i) lst_o <= lst_i;
  end

  p_ivl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ivl_we_i |=> $stable(ivl_o) && $stable(ivl_tgl_o));
endmodule

// File: rtl/ft_frame_cnt.sv
module ft_frame_cnt
  import usb_ft_pkg::*;
#(
  parameter int unsigned IVL_W = 14,
  parameter int unsigned FN_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             oper_i,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             ivl_tgl_i,
  output logic [IVL_W-1:0] rem_o,
  output logic             rem_tgl_o,
  output logic [FN_W-1:0]  fn_o,
  output logic             run_o,
  output logic             load_o,
  output logic             sof_o,
  output logic             fno_o
);
  ft_phase_e       phase;
  logic            reload;
  logic [FN_W-1:0] fn_nx;

  always_comb begin
    if (!oper_i)     phase = FT_IDLE;
    else if (!run_o) phase = FT_START;
    else             phase = FT_RUN;
  end

  assign reload = (phase == FT_RUN) && tick_i && (rem_o == '0);
  assign load_o = reload || (phase == FT_START);
  assign fn_nx  = fn_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o     <= 1'b0;
      rem_o     <= '0;
      rem_tgl_o <= 1'b0;
      fn_o      <= '0;
      sof_o     <= 1'b0;
      fno_o     <= 1'b0;
    end else begin
      sof_o <= 1'b0;
      fno_o <= 1'b0;
      unique case (phase)
        FT_IDLE: begin
          run_o <= 1'b0;
          rem_o <= '0;
        end
        FT_START: begin
          run_o     <= 1'b1;
          rem_o     <= ivl_i;
          rem_tgl_o <= ivl_tgl_i;
        end
        default: begin
          if (reload) begin
            rem_o     <= ivl_i;
            rem_tgl_o <= ivl_tgl_i;
            fn_o      <= fn_nx;
            sof_o     <= 1'b1;
            fno_o     <= fn_nx[FN_W-1] ^ fn_o[FN_W-1];
          end else if (tick_i) begin
            rem_o <= rem_o - 1'b1;
          end
        end
      endcase
    end
  end

  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && oper_i && tick_i && rem_o != '0) |=> rem_o == $past(rem_o) - 1'b1);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && oper_i && !tick_i) |=> $stable(rem_o) && !sof_o);
  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && oper_i && tick_i && rem_o == '0) |=> sof_o && rem_o == $past(ivl_i)
      && rem_tgl_o == $past(ivl_tgl_i));
  p_fn_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> fn_o == $past(fn_o) + 1'b1);
  p_fno_sof_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fno_o |-> sof_o && fn_o[FN_W-2:0] == '0);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oper_i |=> !sof_o && !fno_o && rem_o == '0 && $stable(fn_o));
  p_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oper_i && !run_o) |=> !sof_o && rem_o == $past(ivl_i));
endmodule

// File: rtl/ft_budget_cmp.sv
module ft_budget_cmp #(
  parameter int unsigned IVL_W = 14,
  parameter int unsigned PKT_W = 15,
  parameter int unsigned LST_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             oper_i,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [PKT_W-1:0] pkt_i,
  input  logic [IVL_W-1:0] rem_i,
  input  logic [IVL_W-1:0] pst_i,
  input  logic [LST_W-1:0] lst_i,
  output logic [PKT_W-1:0] budget_o,
  output logic             fits_o,
  output logic             per_ok_o,
  output logic             ls_ok_o
);
  localparam int unsigned CMP_W = (IVL_W > LST_W) ? IVL_W : LST_W;

  logic [CMP_W-1:0] rem_x, lst_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      budget_o <= '0;
    else if (!oper_i)                 budget_o <= '0;
    else if (load_i)                  budget_o <= pkt_i;
    else if (tick_i && budget_o != '0) budget_o <= budget_o - 1'b1;
  end

  assign rem_x    = CMP_W'(rem_i);
  assign lst_x    = CMP_W'(lst_i);
  assign fits_o   = run_i && (budget_o != '0);
  assign per_ok_o = run_i && (rem_i <= pst_i);
  assign ls_ok_o  = run_i && (rem_x > lst_x);

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oper_i && load_i) |=> budget_o == $past(pkt_i));
  p_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (budget_o == '0 && !load_i) |=> budget_o == '0);
  p_flags_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !per_ok_o && !ls_ok_o && !fits_o);
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usb_ft_pkg::*;
#(
  parameter int unsigned IVL_W   = IVL_W_DEF,
  parameter int unsigned FN_W    = FN_W_DEF,
  parameter int unsigned PKT_W   = PKT_W_DEF,
  parameter int unsigned LST_W   = LST_W_DEF,
  parameter int unsigned IVL_RST = IVL_RST_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             oper_i,
  input  logic             ivl_we_i,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             ivl_tgl_i,
  input  logic [PKT_W-1:0] pkt_i,
  input  logic             pst_we_i,
  input  logic [IVL_W-1:0] pst_i,
  input  logic             lst_we_i,
  input  logic [LST_W-1:0] lst_i,
  output logic [IVL_W-1:0] rem_o,
  output logic             rem_tgl_o,
  output logic [FN_W-1:0]  frame_num_o,
  output logic             sof_o,
  output logic             fno_o,
  output logic [PKT_W-1:0] budget_o,
  output logic             pkt_fits_o,
  output logic             periodic_ok_o,
  output logic             ls_ok_o
);
  logic [IVL_W-1:0] ivl_q, pst_q;
  logic             ivl_tgl_q, run, load;
  logic [PKT_W-1:0] pkt_q;
  logic [LST_W-1:0] lst_q;

  ft_cfg_regs #(.IVL_W(IVL_W), .PKT_W(PKT_W), .LST_W(LST_W), .IVL_RST(IVL_RST)) u_cfg (
    .clk_i, .rst_ni,
    .ivl_we_i, .ivl_i, .ivl_tgl_i, .pkt_i,
    .pst_we_i, .pst_i, .lst_we_i, .lst_i,
    .ivl_o(ivl_q), .ivl_tgl_o(ivl_tgl_q), .pkt_o(pkt_q), .pst_o(pst_q), .lst_o(lst_q)
  );

  ft_frame_cnt #(.IVL_W(IVL_W), .FN_W(FN_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i(bit_tick_i), .oper_i,
    .ivl_i(ivl_q), .ivl_tgl_i(ivl_tgl_q),
    .rem_o, .rem_tgl_o, .fn_o(frame_num_o),
    .run_o(run), .load_o(load), .sof_o, .fno_o
  );

  ft_budget_cmp #(.IVL_W(IVL_W), .PKT_W(PKT_W), .LST_W(LST_W)) u_bud (
    .clk_i, .rst_ni,
    .tick_i(bit_tick_i), .oper_i, .load_i(load), .run_i(run),
    .pkt_i(pkt_q), .rem_i(rem_o), .pst_i(pst_q), .lst_i(lst_q),
    .budget_o, .fits_o(pkt_fits_o), .per_ok_o(periodic_ok_o), .ls_ok_o
  );

  p_rst_r1: assert property (@(posedge clk_i) $rose(rst_ni) |-> frame_num_o == '0 && !sof_o);
endmodule

// File: tb/usb_frame_timer_tb.sv
module usb_frame_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, oper = 1'b0;
  logic        ivl_we = 1'b0, ivl_tgl = 1'b0, pst_we = 1'b0, lst_we = 1'b0;
  logic [13:0] ivl = '0, pst = '0;
  logic [14:0] pkt = '0;
  logic [11:0] lst = '0;
  logic [13:0] rem;
  logic        rem_tgl, sof, fno, fits, per_ok, ls_ok;
  logic [15:0] fn;
  logic [14:0] budget;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_frame_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .oper_i(oper),
    .ivl_we_i(ivl_we), .ivl_i(ivl), .ivl_tgl_i(ivl_tgl), .pkt_i(pkt),
    .pst_we_i(pst_we), .pst_i(pst), .lst_we_i(lst_we), .lst_i(lst),
    .rem_o(rem), .rem_tgl_o(rem_tgl), .frame_num_o(fn), .sof_o(sof), .fno_o(fno),
    .budget_o(budget), .pkt_fits_o(fits), .periodic_ok_o(per_ok), .ls_ok_o(ls_ok)
  );

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // writes hold tick low so that frame counts stay in ticks
  task automatic wr_ivl(logic [13:0] v, logic t, logic [14:0] p);
    logic tk = tick;
    tick = 0; ivl_we = 1; ivl = v; ivl_tgl = t; pkt = p;
    @(negedge clk);
    ivl_we = 0; tick = tk;
  endtask

  task automatic wr_cmp(logic [13:0] ps, logic [11:0] ls);
    logic tk = tick;
    tick = 0; pst_we = 1; lst_we = 1; pst = ps; lst = ls;
    @(negedge clk);
    pst_we = 0; lst_we = 0; tick = tk;
  endtask

  // ticks until sof, returns count of clocks
  task automatic to_sof(output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!sof && n < 20000);
  endtask

  task automatic t_reset;
    check("R1 rem", rem, 0);
    check("R1 fn", fn, 0);
    check("R1 sof", sof, 0);
    check("R1 fno", fno, 0);
    check("R1 budget", budget, 0);
    check("R1 flags", {rem_tgl, fits, per_ok, ls_ok}, 0);
  endtask

  task automatic t_first_sof;
    int n;
    wr_ivl(14'd9, 1'b0, 15'd4);
    tick = 1; oper = 1;
    to_sof(n);
    check("R9 first frame clocks", n, 11);
    check("R4 fn after first sof", fn, 1);
    check("R3 rem at reload", rem, 9);
    @(negedge clk);
    check("R4 sof one clock", sof, 0);
    check("R2 rem decrements", rem, 8);
  endtask

  task automatic t_period;
    int n;
    to_sof(n);
    check("R3 frame length ivl+1 (after 1 tick)", n, 9);
    to_sof(n);
    check("R3 frame length ivl+1", n, 10);
    check("R4 fn count", fn, 3);
  endtask

  task automatic t_tick_gate;
    logic [13:0] r0;
    repeat (3) @(negedge clk);
    tick = 0;
    r0 = rem;
    repeat (5) @(negedge clk);
    check("R2 rem held without tick", rem, r0);
    check("R2 no sof without tick", sof, 0);
    tick = 1;
    @(negedge clk);
    check("R2 rem resumes", rem, r0 - 1);
  endtask

  task automatic t_retime;
    int n;
    to_sof(n);
    repeat (2) @(negedge clk);
    wr_ivl(14'd6, 1'b1, 15'd4);
    check("R3 toggle waits for reload", rem_tgl, 0);
    check("R3 rem unaffected by write", rem, 7);
    to_sof(n);
    check("R3 old frame finishes", n, 8);
    check("R3 new ivl loaded", rem, 6);
    check("R3 toggle copied", rem_tgl, 1);
    to_sof(n);
    check("R3 new frame length", n, 7);
  endtask

  task automatic t_budget_cmp;
    int n;
    wr_ivl(14'd9, 1'b0, 15'd4);
    wr_cmp(14'd5, 12'd3);
    to_sof(n);
    check("R6 budget loaded", budget, 4);
    check("R6 fits", fits, 1);
    check("R7 per_ok low at 9", per_ok, 0);
    check("R8 ls_ok high at 9", ls_ok, 1);
    repeat (2) @(negedge clk);
    check("R6 budget dec", budget, 2);
    repeat (2) @(negedge clk);
    check("R6 budget zero", budget, 0);
    check("R6 fits low", fits, 0);
    check("R7 per_ok at rem=pst", {rem, per_ok}, {14'd5, 1'b1});
    @(negedge clk);
    check("R7 per_ok below pst", per_ok, 1);
    check("R8 ls_ok at rem=4", ls_ok, 1);
    @(negedge clk);
    check("R8 ls_ok low at rem=lst", {rem, ls_ok}, {14'd3, 1'b0});
    repeat (3) @(negedge clk);
    check("R6 budget saturates", budget, 0);
    to_sof(n);
    check("R6 budget reloaded", budget, 4);
  endtask

  task automatic t_stop;
    logic [15:0] f0;
    int seen = 0;
    f0 = fn;
    oper = 0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      if (sof || fno) seen++;
      @(negedge clk);
    end
    check("R10 no pulses idle", seen, 0);
    check("R10 fn held", fn, f0);
    check("R10 rem zero", rem, 0);
    check("R10 budget zero", budget, 0);
    check("R10 flags low", {fits, per_ok, ls_ok}, 0);
    oper = 1;
  endtask

  task automatic t_fno;
    int n, cnt = 0, bad = 0;
    wr_ivl(14'd0, 1'b0, 15'd1);
    to_sof(n);
    to_sof(n);
    for (int i = 0; i < 65540; i++) begin
      @(negedge clk);
      if (fno) begin
        cnt++;
        if (fn != 16'h8000 && fn != 16'h0000) bad++;
        if (!sof) bad++;
      end
    end
    check("R5 fno count both directions", cnt, 2);
    check("R5 fno at msb change with sof", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_first_sof();
    t_period();
    t_tick_gate();
    t_retime();
    t_budget_cmp();
    t_stop();
    t_fno();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule